// File: doc/BRIEF.md
# Framed Serial Message Transmitter

This block sends one framed message over a two-wire link: a clock output it always drives, and a data line it enables only while a byte is being shifted. A single start pulse begins a transfer. The block reads the frame length from the header held in a small external byte buffer. It then fetches each byte through a synchronous read port and shifts it out most significant bit first. After the last counted byte it appends a checksum that brings the byte sum of the frame to zero.

Before finishing, the block holds the link quiet for a settling interval. `busy_o` stays high for the whole transfer, so a receiver on the same link can use it to drop frames while the local side is talking. If the caller reports that a reception completed shortly before, the block inserts a guard wait before the first byte. The header is laid out as target unit, sub-address (0x00 addresses every unit with that target ID), sender ID, length, command and payload. The command codes in use are 0xD3 (clear), 0xD5 (cursor position, with 0x00 or 0x40 selecting the line) and 0xD7 (text, up to 20 payload bytes). The block does not interpret any of them; it only sends them.

Top module: `frame_tx`

## Requirements
- R1: Under reset, `busy_o`, `done_o`, `ser_clk_o`, `ser_oe_o` and `ser_data_o` are all 0.
- R2: The byte at buffer address 3 gives the count N of bytes to send. The block sends the bytes at addresses 0 to N-1 in ascending order, followed by exactly one checksum byte.
- R3: Each byte goes out as 8 bits, most significant first. The receiver samples each bit on the rising edge of `ser_clk_o`, and `ser_data_o` does not change while `ser_clk_o` is high.
- R4: The checksum byte equals (0 - sum of the N sent bytes) mod 256, so the sum of all frame bytes is 0 mod 256.
- R5: `ser_clk_o` stays high for exactly HIGH_CYC cycles per bit. Within a byte, each bit's data is valid with the clock low for exactly SETUP_CYC cycles before the rising edge.
- R6: `ser_oe_o` is high whenever `ser_clk_o` is high. It is released after every byte, and whenever `ser_oe_o` is low, `ser_data_o` is 0.
- R7: `busy_o` goes high on the edge that accepts start and stays high through the last bit. `done_o` rises exactly SETTLE_CYC cycles after the final falling edge of `ser_clk_o`.
- R8: The first rising edge of `ser_clk_o` comes 4+SETUP_CYC cycles after the accepting edge when `rx_recent_i` is low at that edge, and GUARD_CYC cycles later when it is high.
- R9: A start pulse while `busy_o` is high is ignored: the frame in flight is unchanged and no second frame follows.
- R10: `done_o` is a one-cycle pulse in the cycle `busy_o` first reads low.
- R11: A count of 0 sends only a single checksum byte of value 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to send the buffered frame |
| rx_recent_i | input | 1 | High if a reception just finished; sampled with start |
| buf_addr_o | output | AW | Buffer read address |
| buf_data_i | input | 8 | Buffer read data, valid one cycle after the address |
| ser_clk_o | output | 1 | Link clock |
| ser_data_o | output | 1 | Link data value |
| ser_oe_o | output | 1 | Data line drive enable |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at end of transfer |

## Verification
Results arrive at fixed delays after the edge that accepts start. `busy_o` is high right after that edge. The first link clock rise follows 4+SETUP_CYC cycles later, plus GUARD_CYC when the guard applies. `done_o` follows the last clock fall by exactly SETTLE_CYC cycles. A free-running cycle counter in the bench stamps each of these events at the falling clock edge, away from the edge where the design updates, and the bench compares the differences against those formulas. Bit values, clock-high widths and setup gaps are collected by the same negative-edge monitor and checked once the frame's `done_o` pulse has arrived.

// File: rtl/frame_tx_pkg.sv
`timescale 1ns/1ps
// Shared constants and controller state type for the framed transmitter.
package frame_tx_pkg;
    localparam int BYTE_W  = 8;   // bits per link byte
    localparam int CNT_IDX = 3;   // buffer address of the length byte

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GUARD,
        ST_RD_CNT,
        ST_CNT_WAIT,
        ST_RD_BYTE,
        ST_BYTE_WAIT,
        ST_SEND,
        ST_CSUM,
        ST_SEND_CK,
        ST_SETTLE
    } tx_state_t;
endpackage

// File: rtl/frame_tx_csum.sv
`timescale 1ns/1ps
// Running 8-bit sum of sent bytes, offering its two's-complement negation.
// Assumes clr_i and add_i are never high in the same cycle.
module frame_tx_csum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         add_i,
    input  logic [W-1:0] byte_i,
    output logic [W-1:0] neg_o
);
    logic [W-1:0] sum_q;

    // Accumulate each byte handed to the serializer; cleared per frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sum_q <= '0;
        end else if (add_i) begin
            sum_q <= sum_q + byte_i;
        end
    end

    assign neg_o = W'(0) - sum_q;

    p_clr_add_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        add_i |-> !clr_i);
endmodule

// File: rtl/frame_tx_bitser.sv
`timescale 1ns/1ps
// Bit serializer: shifts one loaded byte MSB first. Each bit holds clock low
// for SETUP_CYC cycles, then high for HIGH_CYC cycles. The data driver is
// enabled for the byte only and its value is forced low on release.
// Assumes ld_i arrives only while idle (oe_q low).
module frame_tx_bitser
    import frame_tx_pkg::*;
#(
    parameter int SETUP_CYC = 20,
    parameter int HIGH_CYC  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              byte_done_o,
    output logic              ser_clk_o,
    output logic              ser_data_o,
    output logic              ser_oe_o
);
    localparam int TMAX = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BW   = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh_q;
    logic [BW-1:0]     bit_q;
    logic [TW-1:0]     tmr_q;
    logic              clk_q;
    logic              oe_q;
    logic              dat_q;
    logic              last_bit;
    logic              high_end;

    assign last_bit = (bit_q == BW'(BYTE_W - 1));
    assign high_end = oe_q && clk_q && (tmr_q == TW'(HIGH_CYC - 1));

    // Bit sequencing: setup phase with clock low, then the clock-high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= '0;
            tmr_q <= '0;
            clk_q <= 1'b0;
            oe_q  <= 1'b0;
            dat_q <= 1'b0;
        end else if (ld_i && !oe_q) begin
            sh_q  <= byte_i;
            bit_q <= '0;
            tmr_q <= '0;
            clk_q <= 1'b0;
            oe_q  <= 1'b1;
            dat_q <= byte_i[BYTE_W-1];
        end else if (oe_q) begin
            if (!clk_q) begin
                if (tmr_q == TW'(SETUP_CYC - 1)) begin
                    clk_q <= 1'b1;
                    tmr_q <= '0;
                end else begin
                    tmr_q <= tmr_q + 1'b1;
                end
            end else if (high_end) begin
                clk_q <= 1'b0;
                tmr_q <= '0;
                if (last_bit) begin
                    oe_q  <= 1'b0;
                    dat_q <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                    dat_q <= sh_q[BYTE_W-2];
                end
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign byte_done_o = high_end && last_bit;
    assign ser_clk_o   = clk_q;
    assign ser_data_o  = dat_q;
    assign ser_oe_o    = oe_q;

    p_hold_while_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_q && $past(clk_q)) |-> $stable(dat_q));
    p_released_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_q |-> !dat_q);
    p_clk_needs_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_q |-> oe_q);
    p_no_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |-> !oe_q);
endmodule

// File: rtl/frame_tx_ctrl.sv
`timescale 1ns/1ps
// Frame controller: accepts start, optionally waits a guard interval, reads
// the length byte, walks the buffer, then sends the checksum and settles.
// Assumes a buffer with one cycle of read latency.
module frame_tx_ctrl
    import frame_tx_pkg::*;
#(
    parameter int AW         = 5,
    parameter int SETTLE_CYC = 4000000,
    parameter int GUARD_CYC  = 4000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rx_recent_i,
    input  logic [BYTE_W-1:0] buf_data_i,
    input  logic              byte_done_i,
    input  logic [BYTE_W-1:0] csum_neg_i,
    output logic [AW-1:0]     buf_addr_o,
    output logic              ld_o,
    output logic [BYTE_W-1:0] ld_byte_o,
    output logic              sum_clr_o,
    output logic              sum_add_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int TMAX = (SETTLE_CYC > GUARD_CYC) ? SETTLE_CYC : GUARD_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    tx_state_t         st_q;
    logic [BYTE_W-1:0] idx_q;
    logic [BYTE_W-1:0] cnt_q;
    logic [TW-1:0]     tmr_q;
    logic              busy_q;
    logic              done_q;
    logic              accept;

    assign accept = (st_q == ST_IDLE) && start_i;

    // Frame sequencing and the guard/settle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            cnt_q  <= '0;
            tmr_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        busy_q <= 1'b1;
                        tmr_q  <= '0;
                        idx_q  <= '0;
                        st_q   <= rx_recent_i ? ST_GUARD : ST_RD_CNT;
                    end
                end
                ST_GUARD: begin
                    if (tmr_q == TW'(GUARD_CYC - 1)) begin
                        tmr_q <= '0;
                        st_q  <= ST_RD_CNT;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_RD_CNT:   st_q <= ST_CNT_WAIT;
                ST_CNT_WAIT: begin
                    cnt_q <= buf_data_i;
                    st_q  <= (buf_data_i == '0) ? ST_CSUM : ST_RD_BYTE;
                end
                ST_RD_BYTE:   st_q <= ST_BYTE_WAIT;
                ST_BYTE_WAIT: st_q <= ST_SEND;
                ST_SEND: begin
                    if (byte_done_i) begin
                        if (BYTE_W'(idx_q + 1'b1) == cnt_q) begin
                            st_q <= ST_CSUM;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= ST_RD_BYTE;
                        end
                    end
                end
                ST_CSUM: st_q <= ST_SEND_CK;
                ST_SEND_CK: begin
                    if (byte_done_i) begin
                        tmr_q <= '0;
                        st_q  <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_q == TW'(SETTLE_CYC - 1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Buffer address, serializer load and checksum strobes per state.
    always_comb begin
        buf_addr_o = (st_q == ST_RD_CNT) ? AW'(CNT_IDX) : idx_q[AW-1:0];
        ld_o       = (st_q == ST_BYTE_WAIT) || (st_q == ST_CSUM);
        ld_byte_o  = (st_q == ST_CSUM) ? csum_neg_i : buf_data_i;
        sum_add_o  = (st_q == ST_BYTE_WAIT);
        sum_clr_o  = accept;
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEND) |-> (idx_q < cnt_q));
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: rtl/frame_tx.sv
`timescale 1ns/1ps
// Framed serial message transmitter top: controller, bit serializer and
// checksum generator. The link data line is driven only while ser_oe_o is
// high. Assumes a buffer with one cycle of read latency on buf_addr_o.
module frame_tx
    import frame_tx_pkg::*;
#(
    parameter int AW         = 5,
    parameter int SETUP_CYC  = 20,
    parameter int HIGH_CYC   = 200,
    parameter int SETTLE_CYC = 4000000,
    parameter int GUARD_CYC  = 4000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rx_recent_i,
    output logic [AW-1:0]     buf_addr_o,
    input  logic [BYTE_W-1:0] buf_data_i,
    output logic              ser_clk_o,
    output logic              ser_data_o,
    output logic              ser_oe_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              ld;
    logic [BYTE_W-1:0] ld_byte;
    logic              byte_done;
    logic              sum_clr;
    logic              sum_add;
    logic [BYTE_W-1:0] csum_neg;

    frame_tx_ctrl #(
        .AW(AW), .SETTLE_CYC(SETTLE_CYC), .GUARD_CYC(GUARD_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_recent_i(rx_recent_i),
        .buf_data_i(buf_data_i), .byte_done_i(byte_done), .csum_neg_i(csum_neg),
        .buf_addr_o(buf_addr_o), .ld_o(ld), .ld_byte_o(ld_byte),
        .sum_clr_o(sum_clr), .sum_add_o(sum_add),
        .busy_o(busy_o), .done_o(done_o)
    );

    frame_tx_bitser #(
        .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .ld_i(ld), .byte_i(ld_byte),
        .byte_done_o(byte_done), .ser_clk_o(ser_clk_o),
        .ser_data_o(ser_data_o), .ser_oe_o(ser_oe_o)
    );

    frame_tx_csum #(.W(BYTE_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .clr_i(sum_clr), .add_i(sum_add),
        .byte_i(ld_byte), .neg_o(csum_neg)
    );

    p_clk_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_o |-> busy_o);
endmodule

// File: tb/frame_tx_tb.sv
`timescale 1ns/1ps
module frame_tx_tb;
    localparam int AW     = 5;
    localparam int SETUP  = 3;
    localparam int HIGH   = 5;
    localparam int SETTLE = 40;
    localparam int GUARD  = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rx_recent = 1'b0;
    logic [AW-1:0] buf_addr;
    logic [7:0] buf_q;
    logic ser_clk, ser_data, ser_oe, busy, done;

    logic [7:0] mem [0:31];
    int checks = 0, errors = 0, cyc = 0;

    // monitor state
    int rx [0:63];
    int nrx, bits, shreg, cur_bit, hi_run, low_run;
    int tim_err, data_err, rel_err, oe_err, busy_err;
    int first_rise, last_fall, done_cyc, done_cnt, done_hi, done_busy;
    logic prev_clk = 1'b0;

    always #2.5 clk = ~clk;

    frame_tx #(.AW(AW), .SETUP_CYC(SETUP), .HIGH_CYC(HIGH),
               .SETTLE_CYC(SETTLE), .GUARD_CYC(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rx_recent_i(rx_recent),
        .buf_addr_o(buf_addr), .buf_data_i(buf_q), .ser_clk_o(ser_clk),
        .ser_data_o(ser_data), .ser_oe_o(ser_oe), .busy_o(busy), .done_o(done)
    );

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        buf_q <= mem[buf_addr];
    end

    // link monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (ser_clk && !prev_clk) begin
            if (first_rise < 0) first_rise = cyc;
            if (bits != 0 && low_run != SETUP) tim_err++;
            if (!ser_oe) oe_err++;
            shreg = ((shreg << 1) | int'(ser_data)) & 8'hFF;
            cur_bit = int'(ser_data);
            hi_run = 1;
            bits++;
            if (bits == 8) begin
                if (nrx < 64) rx[nrx] = shreg;
                nrx++;
                bits = 0;
            end
        end else if (ser_clk) begin
            hi_run++;
            if (int'(ser_data) != cur_bit) data_err++;
            if (!ser_oe) oe_err++;
        end
        if (!ser_clk && prev_clk) begin
            if (hi_run != HIGH) tim_err++;
            last_fall = cyc;
            low_run = 1;
        end else if (!ser_clk) begin
            low_run++;
        end
        if (!ser_oe && ser_data) rel_err++;
        if (ser_clk && !busy) busy_err++;
        if (done) begin
            if (done_cnt == 0) done_cyc = cyc;
            done_cnt++;
            done_hi++;
            if (busy) done_busy++;
        end
        prev_clk = ser_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nrx = 0; bits = 0; shreg = 0; cur_bit = 0; hi_run = 0; low_run = 0;
        tim_err = 0; data_err = 0; rel_err = 0; oe_err = 0; busy_err = 0;
        first_rise = -1; last_fall = 0; done_cyc = 0; done_cnt = 0;
        done_hi = 0; done_busy = 0;
    endtask

    // Pulse start; returns the cycle stamp of the accepting edge.
    task automatic launch(input bit recent, output int scyc);
        @(negedge clk);
        start = 1'b1;
        rx_recent = recent;
        @(posedge clk);
        #1 scyc = cyc;
        check(busy == 1'b1, "R7", int'(busy), 1);
        @(negedge clk);
        start = 1'b0;
        rx_recent = 1'b0;
    endtask

    task automatic wait_done();
        for (int t = 0; t < 20000 && done_cnt == 0; t++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // Compare a finished frame against the buffer contents.
    task automatic check_frame(input string nm);
        int cnt, sum, bad, ck;
        cnt = int'(mem[3]);
        sum = 0;
        bad = 0;
        check(nrx == cnt + 1, "R2", nrx, cnt + 1);
        for (int i = 0; i < cnt && i < nrx; i++) begin
            if (rx[i] != int'(mem[i])) bad++;
            sum += int'(mem[i]);
        end
        check(bad == 0, "R3", bad, 0);
        ck = (256 - (sum % 256)) % 256;
        if (nrx > cnt) begin
            check(rx[cnt] == ck, "R4", rx[cnt], ck);
            check(((sum + rx[cnt]) % 256) == 0, "R4", (sum + rx[cnt]) % 256, 0);
        end
        check(tim_err == 0, "R5", tim_err, 0);
        check(data_err == 0, "R3", data_err, 0);
        check(rel_err == 0 && oe_err == 0, "R6", rel_err + oe_err, 0);
        check(busy_err == 0, "R7", busy_err, 0);
        check(done_cyc - last_fall == SETTLE, "R7", done_cyc - last_fall, SETTLE);
        check(done_hi == 1 && done_busy == 0, "R10", done_hi, 1);
        check(busy == 1'b0, "R10", int'(busy), 0);
        $display("frame %s: %0d bytes", nm, nrx);
    endtask

    task automatic load_hdr(input int n, input int cmd);
        for (int i = 0; i < 32; i++) mem[i] = 8'(i * 7 + 1);
        mem[0] = 8'h21; mem[1] = 8'h00; mem[2] = 8'hF0;
        mem[3] = 8'(n); mem[4] = 8'(cmd);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        start = 1'b1;
        repeat (4) @(negedge clk);
        check({busy, done, ser_clk, ser_oe, ser_data} == 5'b0, "R1",
              int'({busy, done, ser_clk, ser_oe, ser_data}), 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({busy, done, ser_clk, ser_oe} == 4'b0, "R1",
              int'({busy, done, ser_clk, ser_oe}), 0);
    endtask

    task automatic test_clear_cmd();
        int s;
        load_hdr(5, 'hD3);
        clear_mon();
        launch(1'b0, s);
        wait_done();
        check(first_rise - s == 4 + SETUP, "R8", first_rise - s, 4 + SETUP);
        check_frame("clear");
    endtask

    task automatic test_cursor_line2();
        int s;
        load_hdr(6, 'hD5);
        mem[5] = 8'h40;
        clear_mon();
        launch(1'b0, s);
        wait_done();
        check_frame("cursor");
    endtask

    task automatic test_text_max();
        int s;
        load_hdr(25, 'hD7);
        for (int i = 5; i < 25; i++) mem[i] = 8'(8'h41 + i);
        mem[7] = 8'hFF; mem[8] = 8'h80;
        clear_mon();
        launch(1'b0, s);
        wait_done();
        check_frame("text");
    endtask

    task automatic test_guard();
        int s;
        load_hdr(5, 'hD3);
        clear_mon();
        launch(1'b1, s);
        wait_done();
        check(first_rise - s == 4 + SETUP + GUARD, "R8", first_rise - s, 4 + SETUP + GUARD);
        check_frame("guard");
    endtask

    task automatic test_zero_count();
        int s;
        load_hdr(0, 'hD3);
        clear_mon();
        launch(1'b0, s);
        wait_done();
        check(nrx == 1, "R11", nrx, 1);
        check(rx[0] == 0, "R11", rx[0], 0);
        check(done_cnt == 1, "R11", done_cnt, 1);
    endtask

    task automatic test_start_busy();
        int s;
        load_hdr(6, 'hD5);
        mem[5] = 8'h00;
        clear_mon();
        launch(1'b0, s);
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (60) @(negedge clk);
        check(done_cnt == 1, "R9", done_cnt, 1);
        check(busy == 1'b0 && ser_oe == 1'b0, "R9", int'(busy), 0);
        check(nrx == 7, "R9", nrx, 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 8'h00;
        clear_mon();
        test_reset();
        test_clear_cmd();
        test_cursor_line2();
        test_text_max();
        test_guard();
        test_zero_count();
        test_start_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule